// File: doc/BRIEF.md
# Five-Input Logic Cell with Registered Outputs

This block is a logic cell of the kind an FPGA repeats many times. Two first-level lookup tables each take four inputs. A small second-level table takes the two first-level results and one extra input. With the same four variables on both first-level tables, the cell computes any Boolean function of five variables. When the first-level inputs differ, it covers some functions of up to nine inputs. Two output paths each choose a first-level or second-level result and present it on a combinational output. They also present it, or a direct data input, to a clock-enabled D flip-flop.

All truth tables and path selections come from a 44-bit serial configuration chain. The chain loads one bit per clock while `cfg_en_i` is high, MSB first. A host shifts in a complete image and then drives the logic inputs. The active-low asynchronous reset empties the chain and clears both flip-flops. A separate synchronous clear affects only the flip-flops.

Top module: `clb_cell`

## Requirements
- R1: With selection bit 0 clear, `x_o` equals bit `f_i` of the 16-bit F table. LUT address bit 0 is input 1, and this address order applies to every table.
- R2: With selection bit 1 clear, `y_o` equals bit `g_i` of the 16-bit G table.
- R3: With selection bit 0 set, `x_o` equals bit {`h1_i`, G result, F result} of the 8-bit H table. The F result is address bit 0.
- R4: Put the four low variables on both `f_i` and `g_i`, the fifth on `h1_i`, the cofactor for that variable = 0 in F and the cofactor for it = 1 in G, and H = 8'hCA. Then `x_o` gives the 5-variable function for all 32 input values.
- R5: A configuration image is shifted in MSB first in this order: F table bits 15..0, G table bits 15..0, H table bits 7..0, then selection bits 3..0. That is 44 clocks with `cfg_en_i` high.
- R6: With selection bit 1 set, `y_o` equals the H result.
- R7: On a rising clock edge with `ce_i` high and `srst_i` low, `xq_o` loads `x_o` when selection bit 2 is clear, and `yq_o` loads `y_o` when selection bit 3 is clear.
- R8: With `ce_i` low and `srst_i` low, `xq_o` and `yq_o` hold their values across clock edges.
- R9: With selection bit 2 (bit 3) set, a clock-enabled edge loads `xq_o` from `dx_i` (`yq_o` from `dy_i`).
- R10: On a rising edge with `srst_i` high, `xq_o` and `yq_o` become 0 whatever `ce_i` is.
- R11: While `rst_ni` is low, `xq_o` and `yq_o` are 0 at once and every configuration bit is 0. After reset, every output reads 0 until a new image is loaded.
- R12: While `cfg_en_i` is low, `cfg_bit_i` has no effect and the loaded tables and selections stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_bit_i | input | 1 | Configuration serial data |
| f_i | input | 4 | F table address, bit 0 is input 1 |
| g_i | input | 4 | G table address, bit 0 is input 1 |
| h1_i | input | 1 | Extra input to the H table |
| dx_i | input | 1 | Direct data for the X flip-flop |
| dy_i | input | 1 | Direct data for the Y flip-flop |
| ce_i | input | 1 | Flip-flop clock enable |
| srst_i | input | 1 | Synchronous flip-flop clear |
| x_o | output | 1 | Combinational X result |
| y_o | output | 1 | Combinational Y result |
| xq_o | output | 1 | Registered X |
| yq_o | output | 1 | Registered Y |

## Verification
The bench loads random tables and sweeps every address of each lookup table. It checks the full 32-point truth table of random 5-variable functions, which exposes a reversed address bit or a swapped H-table operand as wrong values at specific indices. A one-hot image pins down the shift order, so a reversed or misaligned chain moves the single 1 to the wrong output index. Flip-flop checks cover enable low, clear taking priority over enable, and the direct data path. They catch a clear gated by enable, or an enable that is ignored. Toggling the serial input while the chain is disabled catches a chain that shifts without enable.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int FG_K   = 4;
  localparam int H_K    = 3;
  localparam int FG_N   = 1 << FG_K;
  localparam int H_N    = 1 << H_K;
  localparam int SEL_W  = 4;
  localparam int CFG_W  = 2 * FG_N + H_N + SEL_W;

  // bit0: X takes H, bit1: Y takes H, bit2: X ff direct, bit3: Y ff direct
  typedef struct packed {
    logic y_ff_dir;
    logic x_ff_dir;
    logic y_use_h;
    logic x_use_h;
  } out_sel_t;
endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
  parameter int W = 44
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] tbl_i,
  input  logic [K-1:0] addr_i,
  output logic         out_o
);
  assign out_o = tbl_i[addr_i];
endmodule

// File: rtl/clb_out_path.sv
module clb_out_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl1_i,
  input  logic lvl2_i,
  input  logic use_lvl2_i,
  input  logic dir_i,
  input  logic d_i,
  input  logic ce_i,
  input  logic srst_i,
  output logic comb_o,
  output logic q_o
);
  logic ff_d;

  assign comb_o = use_lvl2_i ? lvl2_i : lvl1_i;
  assign ff_d   = dir_i ? d_i : comb_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (srst_i) q_o <= 1'b0;
    else if (ce_i)   q_o <= ff_d;
  end
endmodule

// File: rtl/clb_cell.sv
module clb_cell
  import clb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  input  logic [FG_K-1:0]  f_i,
  input  logic [FG_K-1:0]  g_i,
  input  logic             h1_i,
  input  logic             dx_i,
  input  logic             dy_i,
  input  logic             ce_i,
  input  logic             srst_i,
  output logic             x_o,
  output logic             y_o,
  output logic             xq_o,
  output logic             yq_o
);
  localparam int F_HI = CFG_W - 1;
  localparam int G_HI = F_HI - FG_N;
  localparam int H_HI = G_HI - FG_N;

  logic [CFG_W-1:0] cfg_q;
  logic [FG_N-1:0]  f_tbl, g_tbl;
  logic [H_N-1:0]   h_tbl;
  out_sel_t         sel;
  logic             f_res, g_res, h_res;

  logic [1:0] lvl1, use_h, dir, dsel, comb, q;

  clb_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cfg_en_i),
    .bit_i(cfg_bit_i), .q_o(cfg_q)
  );

  assign f_tbl = cfg_q[F_HI -: FG_N];
  assign g_tbl = cfg_q[G_HI -: FG_N];
  assign h_tbl = cfg_q[H_HI -: H_N];
  assign sel   = out_sel_t'(cfg_q[SEL_W-1:0]);

  clb_lut #(.K(FG_K)) u_f (.tbl_i(f_tbl), .addr_i(f_i), .out_o(f_res));
  clb_lut #(.K(FG_K)) u_g (.tbl_i(g_tbl), .addr_i(g_i), .out_o(g_res));
  clb_lut #(.K(H_K))  u_h (.tbl_i(h_tbl), .addr_i({h1_i, g_res, f_res}), .out_o(h_res));

  assign lvl1  = {g_res, f_res};
  assign use_h = {sel.y_use_h, sel.x_use_h};
  assign dir   = {sel.y_ff_dir, sel.x_ff_dir};
  assign dsel  = {dy_i, dx_i};

  for (genvar i = 0; i < 2; i++) begin : g_path
    clb_out_path u_path (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl1_i(lvl1[i]), .lvl2_i(h_res),
      .use_lvl2_i(use_h[i]), .dir_i(dir[i]), .d_i(dsel[i]),
      .ce_i(ce_i), .srst_i(srst_i), .comb_o(comb[i]), .q_o(q[i])
    );
  end

  assign x_o  = comb[0];
  assign y_o  = comb[1];
  assign xq_o = q[0];
  assign yq_o = q[1];
endmodule

// File: rtl/clb_cell_chk.sv
module clb_cell_chk
  import clb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic             cfg_bit_i,
  input logic             ce_i,
  input logic             srst_i,
  input logic             dx_i,
  input logic             dy_i,
  input logic             x_o,
  input logic             y_o,
  input logic             xq_o,
  input logic             yq_o,
  input logic [CFG_W-1:0] cfg_q,
  input out_sel_t         sel
);
  // R5
  cfg_shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_q[0] == $past(cfg_bit_i));

  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_q));

  // R7
  xq_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !srst_i && !sel.x_ff_dir) |=> xq_o == $past(x_o));

  // R7
  yq_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !srst_i && !sel.y_ff_dir) |=> yq_o == $past(y_o));

  // R8
  ff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !srst_i) |=> ($stable(xq_o) && $stable(yq_o)));

  // R9
  xq_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !srst_i && sel.x_ff_dir) |=> xq_o == $past(dx_i));

  // R9
  yq_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !srst_i && sel.y_ff_dir) |=> yq_o == $past(dy_i));

  // R10
  sync_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!xq_o && !yq_o));

  // R11
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      async_clear_chk: assert (!xq_o && !yq_o && cfg_q == '0);
    end
  end
endmodule

bind clb_cell clb_cell_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_bit_i(cfg_bit_i),
  .ce_i(ce_i), .srst_i(srst_i), .dx_i(dx_i), .dy_i(dy_i),
  .x_o(x_o), .y_o(y_o), .xq_o(xq_o), .yq_o(yq_o),
  .cfg_q(cfg_q), .sel(sel)
);

// File: tb/sim_clb_cell.sv
module sim_clb_cell;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_en = 0, cfg_bit = 0, h1 = 0, dx = 0, dy = 0, ce = 0, srst = 0;
  logic [3:0] f = 0, g = 0;
  logic x, y, xq, yq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clb_cell u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en), .cfg_bit_i(cfg_bit),
    .f_i(f), .g_i(g), .h1_i(h1), .dx_i(dx), .dy_i(dy), .ce_i(ce),
    .srst_i(srst), .x_o(x), .y_o(y), .xq_o(xq), .yq_o(yq)
  );

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // sel = {y_ff_dir, x_ff_dir, y_use_h, x_use_h}
  task automatic load(input logic [15:0] ft, input logic [15:0] gt,
                      input logic [7:0] ht, input logic [3:0] sel);
    logic [43:0] img;
    img = {ft, gt, ht, sel};
    for (int i = 43; i >= 0; i--) begin
      @(negedge clk); cfg_en = 1; cfg_bit = img[i];
    end
    @(negedge clk); cfg_en = 0; cfg_bit = 0;
  endtask

  function automatic bit h_ref(logic [7:0] ht, bit fr, bit gr, bit hh);
    return ht[{hh, gr, fr}];
  endfunction

  initial begin
    logic [15:0] ft, gt;
    logic [7:0]  ht;
    logic [31:0] fn;
    bit          prev;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(xq, 0, "R11 xq in reset"); chk(yq, 0, "R11 yq in reset");
    chk(x, 0, "R11 x in reset");   chk(y, 0, "R11 y in reset");
    rst_ni = 1;
    @(negedge clk);

    // R1 R2: first-level tables, full sweep
    for (int k = 0; k < 3; k++) begin
      ft = 16'($urandom); gt = 16'($urandom);
      load(ft, gt, 8'h00, 4'b0000);
      for (int a = 0; a < 16; a++) begin
        f = 4'(a); g = 4'(15 - a); #1;
        chk(x, ft[a], "R1 F table");
        chk(y, gt[15 - a], "R2 G table");
      end
    end

    // R3 R6: second-level table
    ft = 16'($urandom); gt = 16'($urandom); ht = 8'($urandom);
    load(ft, gt, ht, 4'b0011);
    for (int a = 0; a < 512; a++) begin
      f = 4'(a); g = 4'(a >> 4); h1 = a[8]; #1;
      chk(x, h_ref(ht, ft[a[3:0]], gt[a[7:4]], a[8]), "R3 H via X");
      chk(y, h_ref(ht, ft[a[3:0]], gt[a[7:4]], a[8]), "R6 H via Y");
    end

    // R4: random 5-variable functions
    for (int k = 0; k < 4; k++) begin
      fn = $urandom;
      load(fn[15:0], fn[31:16], 8'hCA, 4'b0001);
      for (int v = 0; v < 32; v++) begin
        f = 4'(v); g = 4'(v); h1 = v[4]; #1;
        chk(x, fn[v], "R4 five-variable function");
      end
    end

    // R5: one-hot images pin shift order
    load(16'h8000, 16'h0001, 8'h00, 4'b0000);
    for (int a = 0; a < 16; a++) begin
      f = 4'(a); g = 4'(a); #1;
      chk(x, a == 15, "R5 F order");
      chk(y, a == 0,  "R5 G order");
    end
    load(16'h0000, 16'h0000, 8'h80, 4'b0011);
    f = 0; g = 0; h1 = 1; #1; chk(x, 0, "R5 H order low");
    load(16'hFFFF, 16'hFFFF, 8'h80, 4'b0011);
    h1 = 1; #1; chk(x, 1, "R5 H order high");

    // R7: capture combinational result
    ft = 16'hA5C3; gt = 16'h3C5A;
    load(ft, gt, 8'h00, 4'b0000);
    ce = 1;
    for (int a = 0; a < 16; a++) begin
      f = 4'(a); g = 4'(a);
      @(negedge clk);
      chk(xq, ft[a], "R7 xq capture");
      chk(yq, gt[a], "R7 yq capture");
    end

    // R8: enable low holds
    f = 0; g = 0; @(negedge clk);
    prev = xq;
    ce = 0;
    for (int a = 0; a < 16; a++) begin
      f = 4'(a); g = 4'(a); @(negedge clk);
      chk(xq, prev, "R8 xq hold"); chk(yq, gt[0], "R8 yq hold");
    end

    // R9: direct data inputs
    load(ft, gt, 8'h00, 4'b1100);
    ce = 1;
    for (int a = 0; a < 8; a++) begin
      dx = a[0]; dy = a[1]; f = 4'hF; g = 4'hF;
      @(negedge clk);
      chk(xq, a[0], "R9 xq direct"); chk(yq, a[1], "R9 yq direct");
    end

    // R10: sync clear beats enable
    dx = 1; dy = 1; @(negedge clk);
    srst = 1; @(negedge clk);
    chk(xq, 0, "R10 xq clear"); chk(yq, 0, "R10 yq clear");
    ce = 0; dx = 1; @(negedge clk);
    chk(xq, 0, "R10 xq clear no ce");
    srst = 0;

    // R12: serial input ignored while disabled
    load(16'h1234, 16'hFEDC, 8'h5A, 4'b0000);
    for (int a = 0; a < 50; a++) begin
      cfg_bit = a[0]; @(negedge clk);
    end
    for (int a = 0; a < 16; a++) begin
      f = 4'(a); g = 4'(a); #1;
      chk(x, (16'h1234 >> a) & 1, "R12 F kept");
      chk(y, (16'hFEDC >> a) & 1, "R12 G kept");
    end

    // R11: async reset mid-run
    ce = 1; load(16'hFFFF, 16'hFFFF, 8'hFF, 4'b0000);
    @(negedge clk);
    chk(xq, 1, "R11 xq set before reset");
    #2 rst_ni = 0; #1;
    chk(xq, 0, "R11 async xq"); chk(yq, 0, "R11 async yq");
    @(negedge clk); rst_ni = 1;
    for (int a = 0; a < 16; a++) begin
      f = 4'(a); g = 4'(a); h1 = a[0]; #1;
      chk(x, 0, "R11 config cleared x"); chk(y, 0, "R11 config cleared y");
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule